// File: doc/BRIEF.md
# Serial Host Register Port

This block is a four-wire synchronous serial slave that lets a host processor read and write a 66-byte register file. The first two bytes hold control fields for an audio transmitter: timing-run and mute enables, clock-ratio and audio-format selects, a CRC enable, four per-channel validity flags and a sample-rate code. The remaining 64 bytes are the channel-status and user-bit buffers of four stereo outputs.

A transfer starts when chip select falls and carries 24 bits, most significant first: a 2-bit device code, five ignored bits, a direction flag, an 8-bit register address and 8 data bits. The host changes its data while the serial clock is low, and the block samples it on the rising edge. In a read, the block drives the addressed byte on the eight falling edges that follow the address. The data line is driven only while the block presents read data, so several devices can share it. The serial pins are asynchronous to the system clock. The block samples them through two-flop synchronizers and finds the clock edges in the system clock domain. The decoded control fields leave on registered outputs. The format and clock selects are ORed with external select pins. The audio side reads the buffers through a second, registered byte port.

Top module: `sreg_port`

## Requirements
- R1: A synchronous reset (active-high `rst`, which is also the power-down input) returns every register to its default. Register 0 resets to 0x83 and register 1 to 0x00.
- R2: Channel n (0..3) owns addresses 0x02+16n to 0x11+16n. Offsets 0-3 are the A-side status bytes 0-3, offsets 4-7 the B-side status bytes, offsets 8-11 the A-side user bytes and offsets 12-15 the B-side user bytes. The status defaults are 0x20 for byte 0, 0x00 for byte 1 and 0x02 for byte 3. Byte 2 defaults to 0x10 on the A side and 0x20 on the B side. Every user byte defaults to 0x00.
- R3: A frame is 24 serial-clock rising edges with chip select low. The bits arrive in this order: device code bit 1, device code bit 0, five ignored bits, the direction flag (1 = write, 0 = read), A7..A0, then D7..D0. A matching write stores D7..D0 at the address.
- R4: A frame whose device code is not 2'b11 writes nothing and never enables the data output.
- R5: In a matching read, the byte at the address appears MSB first. The falling edge after the 16th rising edge drives D7, and the following falling edges drive the next bits. `sdo_en_o` is high only during that data phase, and it goes low once chip select rises.
- R6: Writes to addresses 0x42..0xFF leave every register unchanged. Serial and auxiliary reads of those addresses return 0x00.
- R7: If chip select rises before the 24th rising edge, nothing is written.
- R8: The field outputs are decoded from register 0 and register 1. Register 0: bit 7 is the CRC enable, bits 6:4 the format select, bits 3:2 the clock select, bit 1 is active-low mute (1 = running) and bit 0 is the timing run enable. Register 1: bits 7:4 are the validity flags of channels 4..1 and bits 3:0 the sample-rate code.
- R9: `fmt_sel_o` is the bitwise OR of register bits 6:4 and `fmt_pin_i`. `clk_sel_o` is the OR of register bits 3:2 and `clk_pin_i`.
- R10: `aux_data_o` shows the byte at `aux_addr_i` one system clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset / power-down |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial read data |
| sdo_en_o | output | 1 | Output enable for the external tri-state buffer on sdo_o |
| fmt_pin_i | input | 3 | External format select, ORed in |
| clk_pin_i | input | 2 | External clock-ratio select, ORed in |
| crc_en_o | output | 1 | CRC generation enable |
| fmt_sel_o | output | 3 | Effective audio format select |
| clk_sel_o | output | 2 | Effective clock-ratio select |
| mute_n_o | output | 1 | Output active when 1 |
| run_o | output | 1 | Frame/bit counters run when 1 |
| valid_o | output | 4 | Validity flags, channel 4 in bit 3 |
| fs_code_o | output | 4 | Sample-rate code |
| aux_addr_i | input | 8 | Audio-side buffer read address |
| aux_data_o | output | 8 | Audio-side buffer read data |

## Verification
The bench builds the block with its defaults: 66 registers, 8-bit words, device code 2'b11 and two synchronizer stages. With these values the full register space fits inside the 8-bit address, and the addresses 0x42 and above lie in the same serial frame format. Discarded writes and the zero read-back of those addresses can therefore be exercised directly. The 24-bit frame length lets an abort after 20 bits fall inside the data phase of a write. The bench runs the serial clock at 16 system clocks per period, so the synchronizer delay stays well inside each half period.

// File: rtl/sri_pkg.sv
package sri_pkg;
  // reset value of every register; computed from the buffer layout
  function automatic logic [7:0] default_byte(input int a);
    int idx;
    if (a == 0) return 8'h83;
    if (a == 1) return 8'h00;
    idx = (a - 2) % 16;
    if (idx >= 8) return 8'h00;
    case (idx % 4)
      0: return 8'h20;
      1: return 8'h00;
      2: return (idx < 4) ? 8'h10 : 8'h20;
      default: return 8'h02;
    endcase
  endfunction
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= RST_VAL;
      else     stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/sri_frame.sv
module sri_frame #(
  parameter int WORD_W = 8,
  parameter logic [1:0] CHIP_ID = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] acc_addr,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int FRAME_BITS = 2 + 5 + 1 + 2 * WORD_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] POS_CHIP = CNT_W'(1);
  localparam logic [CNT_W-1:0] POS_RW   = CNT_W'(7);
  localparam logic [CNT_W-1:0] POS_ADDR = CNT_W'(7 + WORD_W);
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(8 + WORD_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] sh;
  logic [WORD_W-1:0] nxt;
  logic [WORD_W-1:0] tx;
  logic              chip_ok, is_rd, is_wr, ld_tx;
  logic              rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;
  assign nxt  = {sh, sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b1;
      bit_cnt  <= '0;
      sh       <= '0;
      tx       <= '0;
      chip_ok  <= 1'b0;
      is_rd    <= 1'b0;
      is_wr    <= 1'b0;
      ld_tx    <= 1'b0;
      acc_addr <= '0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      sdo      <= 1'b0;
      sdo_en   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      wr_stb <= 1'b0;
      ld_tx  <= 1'b0;
      if (ld_tx) tx <= rd_data;
      if (csn_s) begin
        bit_cnt <= '0;
        chip_ok <= 1'b0;
        is_rd   <= 1'b0;
        is_wr   <= 1'b0;
        sdo_en  <= 1'b0;
      end else begin
        if (rise && bit_cnt < CNT_FULL) begin
          sh      <= nxt[WORD_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == POS_CHIP) chip_ok <= (nxt[1:0] == CHIP_ID);
          if (bit_cnt == POS_RW) begin
            is_rd <= chip_ok & ~sdi_s;
            is_wr <= chip_ok & sdi_s;
          end
          if (bit_cnt == POS_ADDR) begin
            acc_addr <= nxt;
            ld_tx    <= is_rd;
          end
          if (bit_cnt == POS_LAST && is_wr) begin
            wr_stb  <= 1'b1;
            wr_data <= nxt;
          end
        end
        if (fall) begin
          if (is_rd && bit_cnt >= CNT_DATA && bit_cnt < CNT_FULL) begin
            sdo    <= tx[WORD_W-1];
            tx     <= {tx[WORD_W-2:0], 1'b0};
            sdo_en <= 1'b1;
          end else begin
            sdo_en <= 1'b0;
          end
        end
      end
    end
  end

  AST_EN_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (csn_s && $past(csn_s)) |-> !sdo_en); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_FULL); // R3
  AST_WR_SELECTED: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(!csn_s)); // R7
endmodule

// File: rtl/sri_regfile.sv
module sri_regfile
  import sri_pkg::*;
#(
  parameter int NUM_REGS = 66,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] aux_addr,
  output logic [WORD_W-1:0] aux_data,
  output logic [WORD_W-1:0] ctl0,
  output logic [WORD_W-1:0] ctl1
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(NUM_REGS - 1);

  logic [WORD_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= WORD_W'(default_byte(i));
      aux_data <= '0;
    end else begin
      if (we && acc_addr <= LAST) regs[acc_addr[IDX_W-1:0]] <= wdata;
      aux_data <= (aux_addr <= LAST) ? regs[aux_addr[IDX_W-1:0]] : '0;
    end
  end

  assign rdata = (acc_addr <= LAST) ? regs[acc_addr[IDX_W-1:0]] : '0;
  assign ctl0  = regs[0];
  assign ctl1  = regs[1];

  AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl0 == 8'h83 && ctl1 == 8'h00)); // R1
  AST_HIGH_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (we && acc_addr > LAST) |=> ($stable(ctl0) && $stable(ctl1))); // R6
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(ctl0) && $stable(ctl1))); // R3
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sri_pkg::*;
#(
  parameter int NUM_REGS = 66,
  parameter int WORD_W = 8,
  parameter logic [1:0] CHIP_ID = 2'b11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic [2:0]        fmt_pin_i,
  input  logic [1:0]        clk_pin_i,
  output logic              crc_en_o,
  output logic [2:0]        fmt_sel_o,
  output logic [1:0]        clk_sel_o,
  output logic              mute_n_o,
  output logic              run_o,
  output logic [3:0]        valid_o,
  output logic [3:0]        fs_code_o,
  input  logic [WORD_W-1:0] aux_addr_i,
  output logic [WORD_W-1:0] aux_data_o
);
  localparam logic [7:0] CTL0_RST = default_byte(0);

  logic [2:0]        pins_s;
  logic              csn_s, sclk_s, sdi_s;
  logic [WORD_W-1:0] acc_addr, wr_data, rd_data, ctl0, ctl1;
  logic              wr_stb;

  sri_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .din({csn_i, sclk_i, sdi_i}), .dout(pins_s));
  assign {csn_s, sclk_s, sdi_s} = pins_s;

  sri_frame #(.WORD_W(WORD_W), .CHIP_ID(CHIP_ID)) u_frame (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .acc_addr(acc_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .sdo(sdo_o), .sdo_en(sdo_en_o));

  sri_regfile #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .we(wr_stb), .acc_addr(acc_addr), .wdata(wr_data),
    .rdata(rd_data), .aux_addr(aux_addr_i), .aux_data(aux_data_o),
    .ctl0(ctl0), .ctl1(ctl1));

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_en_o  <= CTL0_RST[7];
      fmt_sel_o <= CTL0_RST[6:4];
      clk_sel_o <= CTL0_RST[3:2];
      mute_n_o  <= CTL0_RST[1];
      run_o     <= CTL0_RST[0];
      valid_o   <= '0;
      fs_code_o <= '0;
    end else begin
      crc_en_o  <= ctl0[7];
      fmt_sel_o <= ctl0[6:4] | fmt_pin_i;
      clk_sel_o <= ctl0[3:2] | clk_pin_i;
      mute_n_o  <= ctl0[1];
      run_o     <= ctl0[0];
      valid_o   <= ctl1[7:4];
      fs_code_o <= ctl1[3:0];
    end
  end

  AST_FMT_OR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fmt_sel_o == ($past(ctl0[6:4]) | $past(fmt_pin_i)))); // R9
  AST_CLK_OR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (clk_sel_o == ($past(ctl0[3:2]) | $past(clk_pin_i)))); // R9
endmodule

// File: tb/test_sreg_port.sv
module test_sreg_port;
  localparam int HALF = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [2:0] fmt_pin = '0;
  logic [1:0] clk_pin = '0;
  logic [7:0] aux_addr = '0;
  logic sdo, sdo_en, crc_en, mute_n, run;
  logic [2:0] fmt_sel;
  logic [1:0] clk_sel;
  logic [3:0] valid, fs_code;
  logic [7:0] aux_data;
  int errors = 0, checks = 0;
  logic [7:0] model [66];

  always #10 clk = ~clk;

  sreg_port i_sreg_port (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .fmt_pin_i(fmt_pin), .clk_pin_i(clk_pin),
    .crc_en_o(crc_en), .fmt_sel_o(fmt_sel), .clk_sel_o(clk_sel),
    .mute_n_o(mute_n), .run_o(run), .valid_o(valid), .fs_code_o(fs_code),
    .aux_addr_i(aux_addr), .aux_data_o(aux_data));

  function automatic logic [7:0] exp_default(int a);
    int ch_off, side, kind, byt;
    if (a == 0) return 8'b1000_0011;
    if (a == 1) return 8'h00;
    ch_off = (a - 2) & 15;
    kind = ch_off >> 3;
    side = (ch_off >> 2) & 1;
    byt  = ch_off & 3;
    if (kind == 1) return 8'h00;
    if (byt == 0) return 8'h20;
    if (byt == 2) return side ? 8'h20 : 8'h10;
    if (byt == 3) return 8'h02;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int a = 0; a < 66; a++) model[a] = exp_default(a);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] chip, input logic rw, input logic [7:0] addr,
                      input logic [7:0] data, input int nbits,
                      output logic [7:0] rd, output logic en_bad);
    logic [23:0] fr;
    fr = {chip, 5'b10110, rw, addr, data};
    rd = '0;
    en_bad = 1'b0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi = fr[23-i];
      wait_clk(HALF);
      if (i >= 16) begin
        rd[23-i] = sdo;
        if (sdo_en !== 1'b1) en_bad = 1'b1;
      end else if (sdo_en !== 1'b0) en_bad = 1'b1;
      sclk = 1'b1;
      wait_clk(HALF);
    end
    csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic sread(input logic [1:0] chip, input logic [7:0] addr, output logic [7:0] rd,
                       output logic en_bad);
    xfer(chip, 1'b0, addr, 8'h00, 24, rd, en_bad);
  endtask

  task automatic swrite(input logic [1:0] chip, input logic [7:0] addr, input logic [7:0] d,
                        input int nbits);
    logic [7:0] rd;
    logic eb;
    xfer(chip, 1'b1, addr, d, nbits, rd, eb);
    if (chip == 2'b11 && nbits == 24 && addr < 8'd66) model[addr] = d;
  endtask

  task automatic aux_rd(input logic [7:0] a, output logic [7:0] d);
    aux_addr = a;
    wait_clk(2);
    d = aux_data;
  endtask

  task automatic sweep(string req);
    logic [7:0] d;
    for (int a = 0; a < 80; a++) begin
      aux_rd(8'(a), d);
      chk(req, d, (a < 66) ? model[a] : 8'h00);
    end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd, d;
    logic eb;
    void'($urandom(32'h1357));
    reset_model();
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    // R1 / R8 reset values on the field outputs
    chk("R1 crc", crc_en, 1); chk("R1 fmt", fmt_sel, 0); chk("R1 cks", clk_sel, 0);
    chk("R1 mute_n", mute_n, 1); chk("R1 run", run, 1);
    chk("R1 valid", valid, 0); chk("R1 fs", fs_code, 0);
    // R2 / R10 default buffer contents via aux port
    sweep("R2_R10 default");
    // R5 serial reads of defaults
    sread(2'b11, 8'h04, rd, eb); chk("R5 read A byte2", rd, 8'h10); chk("R5 enable", eb, 0);
    sread(2'b11, 8'h38, rd, eb); chk("R5 read B byte2 ch4", rd, 8'h20);
    sread(2'b11, 8'h00, rd, eb); chk("R5 read ctl0", rd, 8'h83);
    chk("R5 idle en", sdo_en, 0);
    // R3 / R8 write control regs and decode
    swrite(2'b11, 8'h00, 8'b0_100_10_0_1, 24);
    swrite(2'b11, 8'h01, 8'hA5, 24);
    wait_clk(4);
    chk("R8 crc", crc_en, 0); chk("R8 fmt", fmt_sel, 3'b100); chk("R8 cks", clk_sel, 2'b10);
    chk("R8 mute_n", mute_n, 0); chk("R8 run", run, 1);
    chk("R8 valid", valid, 4'hA); chk("R8 fs", fs_code, 4'h5);
    // R9 OR with pins
    fmt_pin = 3'b011; clk_pin = 2'b01;
    wait_clk(4);
    chk("R9 fmt or", fmt_sel, 3'b111); chk("R9 cks or", clk_sel, 2'b11);
    fmt_pin = '0; clk_pin = '0;
    // R4 wrong device code
    swrite(2'b01, 8'h10, 8'h5A, 24);
    aux_rd(8'h10, d); chk("R4 no write", d, model[8'h10]);
    sread(2'b10, 8'h02, rd, eb); chk("R4 no drive", eb, 1);
    // R6 high addresses
    swrite(2'b11, 8'h42, 8'hFF, 24);
    swrite(2'b11, 8'hFF, 8'hFF, 24);
    sread(2'b11, 8'h42, rd, eb); chk("R6 read high", rd, 8'h00);
    sweep("R6 unchanged");
    // R7 aborted write
    swrite(2'b11, 8'h20, 8'hC3, 20);
    aux_rd(8'h20, d); chk("R7 abort", d, model[8'h20]);
    // R3 boundary: last valid register
    swrite(2'b11, 8'h41, 8'h3C, 24);
    sread(2'b11, 8'h41, rd, eb); chk("R3 last reg", rd, 8'h3C);
    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a, v;
      logic [1:0] c;
      a = 8'($urandom_range(0, 79));
      v = 8'($urandom);
      c = ($urandom_range(0, 3) == 0) ? 2'b10 : 2'b11;
      if ($urandom_range(0, 1) == 1) swrite(c, a, v, 24);
      else begin
        sread(2'b11, a, rd, eb);
        chk("R5 random read", rd, (a < 66) ? model[a] : 8'h00);
        chk("R5 random en", eb, 0);
      end
    end
    sweep("R3 random sweep");
    // R1 reset restores
    rst = 1'b1; wait_clk(3); rst = 1'b0; reset_model(); wait_clk(4);
    chk("R1 restore crc", crc_en, 1); chk("R1 restore valid", valid, 0);
    sweep("R1 restore");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule